// File: doc/BRIEF.md
# Boundary-Scanned Dual-Bank Latch

The block holds two independent 9-bit banks of level-sensitive data latches. Each bank has its own active-high latch enable and its own active-low output enable. Each output bus is modelled as a data vector plus one drive-enable bit, and that enable stands in for a tristate buffer. A 42-cell boundary-scan register wraps the banks. Observe-only cells sit on every input pin. Observe-and-control cells sit on every output pin and on each bank's internal active-high output enable.

A test access controller outside the block runs the register through four strobes: capture, shift, update and mode load. It also supplies a serial input and reads a serial output. In functional mode the pins pass through the latches. The external-test and clamp modes drive the outputs and enables from the scan hold stages. High-impedance mode switches every output off. The banks are built as clocked storage behind a transparent bypass, so the block needs no real latch cells.

Top module: `bscan_dual_latch`

## Requirements
- R1: While a bank's latch enable is 1 in functional mode, that bank's data output equals its data input in the same cycle.
- R2: While a bank's latch enable is 0, its output keeps the input value that was sampled at the last rising clock edge with the enable at 1.
- R3: In functional mode a bank's drive enable is the inverse of its output-enable pin, so a 1 on the pin turns the outputs off. The latch still loads while its outputs are off.
- R4: Each bank's latches respond only to that bank's own latch enable. A bank whose enable is 0 keeps its value while the other bank loads.
- R5: The chain is 42 bits. Bit 41 down to 36 hold: A output-enable pin, A latch enable, internal A enable, B output-enable pin, B latch enable, internal B enable. Bits 35..27 hold A inputs 0..8, 26..18 hold B inputs 0..8, 17..9 hold A outputs 0..8 and 8..0 hold B outputs 0..8. A shift moves every bit one place toward bit 0, loads the serial input into bit 41 and presents bit 0 on the serial output.
- R6: A capture loads every cell from its observed signal: pins for the input cells, the latch outputs for the output cells and the inverted output-enable pins for the internal-enable cells. When capture and shift are both asserted, capture wins.
- R7: An update copies the 20 control cells (bits 0..17, 36 and 39) into the hold stages. The hold stages have no effect on the outputs in functional mode.
- R8: In external-test mode, output bit i of bank A comes from chain bit 17-i and of bank B from bit 8-i. The A enable comes from bit 39 and the B enable from bit 36, whatever the core inputs do.
- R9: Clamp mode drives the outputs from the hold stages like external-test mode, but it ignores update, so the hold stages stay frozen.
- R10: In high-impedance mode both drive enables are 0, whatever the output-enable pins are.
- R11: A mode load latches the 2-bit mode select (00 functional, 01 external test, 10 clamp, 11 high impedance), and the new mode takes effect from the next clock edge.
- R12: After reset the block is in functional mode, and the latches, the scan stages and the hold stages are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and storage clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_din | input | 9 | Bank A data inputs |
| b_din | input | 9 | Bank B data inputs |
| a_le | input | 1 | Bank A latch enable, active high |
| b_le | input | 1 | Bank B latch enable, active high |
| a_oe_n | input | 1 | Bank A output enable, active low |
| b_oe_n | input | 1 | Bank B output enable, active low |
| a_dout | output | 9 | Bank A output data |
| a_dout_en | output | 1 | Bank A drive enable (0 = high impedance) |
| b_dout | output | 9 | Bank B output data |
| b_dout_en | output | 1 | Bank B drive enable (0 = high impedance) |
| scan_tdi | input | 1 | Serial scan input |
| scan_shift | input | 1 | Shift the chain one place |
| scan_capture | input | 1 | Load the chain from observed signals |
| scan_update | input | 1 | Copy control cells to hold stages |
| ir_update | input | 1 | Load the mode select |
| mode_sel | input | 2 | Requested test mode |
| scan_tdo | output | 1 | Serial scan output |

## Verification
The transparent path is combinational, so the R1 and R3 results are read one time step after the inputs change, with no clock edge in between. Latch holding, capture, shift, update and mode loads each act on exactly one rising edge. The bench drives inputs just after the falling edge and reads results half a period after the edge that should have moved them. Checks of the serial output are taken before each shift edge: bit 0 after capture, then one bit per shift.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

  typedef enum logic [1:0] {
    MODE_FUNC   = 2'b00,
    MODE_EXTEST = 2'b01,
    MODE_CLAMP  = 2'b10,
    MODE_HIGHZ  = 2'b11
  } bsl_mode_e;

  // chain length for a given bank width: four data groups plus six control cells
  function automatic int unsigned chain_len(input int unsigned w);
    return 4 * w + 6;
  endfunction

  function automatic int unsigned idx_bo(input int unsigned w, input int unsigned i);
    return w - 1 - i;
  endfunction

  function automatic int unsigned idx_ao(input int unsigned w, input int unsigned i);
    return 2 * w - 1 - i;
  endfunction

  function automatic int unsigned idx_bi(input int unsigned w, input int unsigned i);
    return 3 * w - 1 - i;
  endfunction

  function automatic int unsigned idx_ai(input int unsigned w, input int unsigned i);
    return 4 * w - 1 - i;
  endfunction

  function automatic int unsigned idx_ben(input int unsigned w);
    return 4 * w;
  endfunction

  function automatic int unsigned idx_ble(input int unsigned w);
    return 4 * w + 1;
  endfunction

  function automatic int unsigned idx_boe(input int unsigned w);
    return 4 * w + 2;
  endfunction

  function automatic int unsigned idx_aen(input int unsigned w);
    return 4 * w + 3;
  endfunction

  function automatic int unsigned idx_ale(input int unsigned w);
    return 4 * w + 4;
  endfunction

  function automatic int unsigned idx_aoe(input int unsigned w);
    return 4 * w + 5;
  endfunction

  function automatic logic drives_from_hold(input bsl_mode_e m);
    return (m == MODE_EXTEST) || (m == MODE_CLAMP);
  endfunction

endpackage

// File: rtl/bsl_latch_bank.sv
module bsl_latch_bank
  import bsl_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         oe_n,
  input  bsl_mode_e    mode,
  input  logic [W-1:0] hold_data,
  input  logic         hold_en,
  output logic [W-1:0] core_q,
  output logic         core_en,
  output logic [W-1:0] dout,
  output logic         dout_en
);

  logic [W-1:0] store_q;

  // one storage bit per lane with a transparent bypass while enabled
  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  store_q[i] <= 1'b0;
      else if (le) store_q[i] <= din[i];
    end
    assign core_q[i] = le ? din[i] : store_q[i];
  end

  assign core_en = ~oe_n;

  always_comb begin
    dout    = core_q;
    dout_en = core_en;
    if (drives_from_hold(mode)) begin
      dout    = hold_data;
      dout_en = hold_en;
    end else if (mode == MODE_HIGHZ) begin
      dout_en = 1'b0;
    end
  end

endmodule

// File: rtl/bsl_scan_reg.sv
module bsl_scan_reg
  import bsl_pkg::*;
#(
  parameter int unsigned W   = 9,
  localparam int unsigned LEN = chain_len(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic           shift,
  input  logic           update_en,
  input  logic           tdi,
  input  logic [LEN-1:0] cap_vec,
  output logic [LEN-1:0] sr_q,
  output logic [W-1:0]   a_hold,
  output logic [W-1:0]   b_hold,
  output logic           a_hold_en,
  output logic           b_hold_en,
  output logic           tdo
);

  // shift stages: capture has priority over shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (capture) sr_q <= cap_vec;
    else if (shift)   sr_q <= {tdi, sr_q[LEN-1:1]};
  end

  assign tdo = sr_q[0];

  // hold stages exist only behind the control cells
  for (genvar i = 0; i < W; i++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_hold[i] <= 1'b0;
        b_hold[i] <= 1'b0;
      end else if (update_en) begin
        a_hold[i] <= sr_q[idx_ao(W, i)];
        b_hold[i] <= sr_q[idx_bo(W, i)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_hold_en <= 1'b0;
      b_hold_en <= 1'b0;
    end else if (update_en) begin
      a_hold_en <= sr_q[idx_aen(W)];
      b_hold_en <= sr_q[idx_ben(W)];
    end
  end

endmodule

// File: rtl/bscan_dual_latch.sv
module bscan_dual_latch
  import bsl_pkg::*;
#(
  parameter int unsigned BANK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] a_din,
  input  logic [BANK_W-1:0] b_din,
  input  logic              a_le,
  input  logic              b_le,
  input  logic              a_oe_n,
  input  logic              b_oe_n,
  output logic [BANK_W-1:0] a_dout,
  output logic              a_dout_en,
  output logic [BANK_W-1:0] b_dout,
  output logic              b_dout_en,
  input  logic              scan_tdi,
  input  logic              scan_shift,
  input  logic              scan_capture,
  input  logic              scan_update,
  input  logic              ir_update,
  input  logic [1:0]        mode_sel,
  output logic              scan_tdo
);

  localparam int unsigned LEN = chain_len(BANK_W);

  bsl_mode_e         mode_q;
  logic [BANK_W-1:0] a_core_q, b_core_q;
  logic              a_core_en, b_core_en;
  logic [BANK_W-1:0] a_hold, b_hold;
  logic              a_hold_en, b_hold_en;
  logic [LEN-1:0]    cap_vec;
  logic [LEN-1:0]    sr_q;
  logic              update_en;

  // mode register, loaded by the controller's mode strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= MODE_FUNC;
    else if (ir_update) mode_q <= bsl_mode_e'(mode_sel);
  end

  // clamp keeps the hold stages frozen
  assign update_en = scan_update && (mode_q != MODE_CLAMP);

  bsl_latch_bank #(.W(BANK_W)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .din(a_din), .le(a_le), .oe_n(a_oe_n),
    .mode(mode_q), .hold_data(a_hold), .hold_en(a_hold_en),
    .core_q(a_core_q), .core_en(a_core_en), .dout(a_dout), .dout_en(a_dout_en)
  );

  bsl_latch_bank #(.W(BANK_W)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .din(b_din), .le(b_le), .oe_n(b_oe_n),
    .mode(mode_q), .hold_data(b_hold), .hold_en(b_hold_en),
    .core_q(b_core_q), .core_en(b_core_en), .dout(b_dout), .dout_en(b_dout_en)
  );

  // observed signals laid out in chain order
  always_comb begin
    cap_vec = '0;
    for (int unsigned i = 0; i < BANK_W; i++) begin
      cap_vec[idx_ai(BANK_W, i)] = a_din[i];
      cap_vec[idx_bi(BANK_W, i)] = b_din[i];
      cap_vec[idx_ao(BANK_W, i)] = a_core_q[i];
      cap_vec[idx_bo(BANK_W, i)] = b_core_q[i];
    end
    cap_vec[idx_aoe(BANK_W)] = a_oe_n;
    cap_vec[idx_ale(BANK_W)] = a_le;
    cap_vec[idx_aen(BANK_W)] = a_core_en;
    cap_vec[idx_boe(BANK_W)] = b_oe_n;
    cap_vec[idx_ble(BANK_W)] = b_le;
    cap_vec[idx_ben(BANK_W)] = b_core_en;
  end

  bsl_scan_reg #(.W(BANK_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .capture(scan_capture), .shift(scan_shift),
    .update_en(update_en), .tdi(scan_tdi), .cap_vec(cap_vec), .sr_q(sr_q),
    .a_hold(a_hold), .b_hold(b_hold), .a_hold_en(a_hold_en), .b_hold_en(b_hold_en),
    .tdo(scan_tdo)
  );

endmodule

// File: rtl/bsl_checker.sv
module bsl_checker
  import bsl_pkg::*;
#(
  parameter int unsigned W   = 9,
  localparam int unsigned LEN = chain_len(W)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           a_le,
  input logic [W-1:0]   a_din,
  input logic           a_oe_n,
  input logic [W-1:0]   a_dout,
  input logic           a_dout_en,
  input logic           b_dout_en,
  input logic           scan_tdi,
  input logic           scan_shift,
  input logic           scan_capture,
  input logic           scan_update,
  input logic           ir_update,
  input logic [1:0]     mode_sel,
  input logic [1:0]     mode_q,
  input logic [LEN-1:0] sr_q
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_le && mode_q == MODE_FUNC && !ir_update) |=> (a_le || $stable(a_dout)));

  p_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FUNC) |-> (a_dout_en == !a_oe_n));

  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_shift && !scan_capture) |=> (sr_q == {$past(scan_tdi), $past(sr_q[LEN-1:1])}));

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_capture |=> (sr_q[4*W-1] == $past(a_din[0]) && sr_q[4*W+5] == $past(a_oe_n)));

  p_extest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_EXTEST && !ir_update && scan_update) |=> (a_dout_en == $past(sr_q[4*W+3])));

  p_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CLAMP && !ir_update) |=> ($stable(a_dout) && $stable(a_dout_en)));

  p_highz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_update && mode_sel == MODE_HIGHZ) |=> (!a_dout_en && !b_dout_en));

endmodule

bind bscan_dual_latch bsl_checker #(.W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_le(a_le), .a_din(a_din), .a_oe_n(a_oe_n),
  .a_dout(a_dout), .a_dout_en(a_dout_en), .b_dout_en(b_dout_en),
  .scan_tdi(scan_tdi), .scan_shift(scan_shift), .scan_capture(scan_capture),
  .scan_update(scan_update), .ir_update(ir_update), .mode_sel(mode_sel),
  .mode_q(mode_q), .sr_q(sr_q)
);

// File: tb/bscan_dual_latch_tb.sv
module bscan_dual_latch_tb;

  localparam int W = 9;
  localparam int L = 4 * W + 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_din, b_din, a_dout, b_dout;
  logic a_le, b_le, a_oe_n, b_oe_n, a_dout_en, b_dout_en;
  logic scan_tdi, scan_shift, scan_capture, scan_update, ir_update, scan_tdo;
  logic [1:0] mode_sel;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [W-1:0] ma_q, mb_q;

  always #4 clk = ~clk;

  bscan_dual_latch u_dut (
    .clk(clk), .rst_n(rst_n), .a_din(a_din), .b_din(b_din), .a_le(a_le), .b_le(b_le),
    .a_oe_n(a_oe_n), .b_oe_n(b_oe_n), .a_dout(a_dout), .a_dout_en(a_dout_en),
    .b_dout(b_dout), .b_dout_en(b_dout_en), .scan_tdi(scan_tdi), .scan_shift(scan_shift),
    .scan_capture(scan_capture), .scan_update(scan_update), .ir_update(ir_update),
    .mode_sel(mode_sel), .scan_tdo(scan_tdo)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  // expected chain image built by concatenation, bit 41 first
  function automatic logic [L-1:0] cap_image(input logic [W-1:0] ai, bi, aq, bq,
                                              input logic ale, aoen, ble, boen);
    return {aoen, ale, ~aoen, boen, ble, ~boen, rev(ai), rev(bi), rev(aq), rev(bq)};
  endfunction

  function automatic logic [W-1:0] a_exp();
    return a_le ? a_din : ma_q;
  endfunction

  function automatic logic [W-1:0] b_exp();
    return b_le ? b_din : mb_q;
  endfunction

  task automatic tick();
    if (!rst_n) begin ma_q = '0; mb_q = '0; end
    else begin
      if (a_le) ma_q = a_din;
      if (b_le) mb_q = b_din;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_mode(input logic [1:0] m);
    mode_sel = m; ir_update = 1'b1;
    tick();
    ir_update = 1'b0;
  endtask

  task automatic shift_in(input logic [L-1:0] p, output logic [L-1:0] got);
    for (int k = 0; k < L; k++) begin
      got[k] = scan_tdo;
      scan_tdi = p[k]; scan_shift = 1'b1;
      tick();
    end
    scan_shift = 1'b0;
  endtask

  task automatic do_update();
    scan_update = 1'b1;
    tick();
    scan_update = 1'b0;
  endtask

  task automatic check_from_image(input string req, input logic [L-1:0] p);
    chk(req, a_dout, rev(p[2*W-1:W]));
    chk(req, b_dout, rev(p[W-1:0]));
    chk(req, a_dout_en, p[4*W+3]);
    chk(req, b_dout_en, p[4*W]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] p1, p2, got, exp_img;
    void'($urandom(32'd1234));
    rst_n = 1'b0; a_din = '0; b_din = '0; a_le = 1'b0; b_le = 1'b0;
    a_oe_n = 1'b1; b_oe_n = 1'b1; scan_tdi = 1'b0; scan_shift = 1'b0;
    scan_capture = 1'b0; scan_update = 1'b0; ir_update = 1'b0; mode_sel = 2'b00;
    ma_q = '0; mb_q = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R12: reset state
    chk("R12 a_dout", a_dout, 0);
    chk("R12 tdo", scan_tdo, 0);
    a_oe_n = 1'b0; #1;
    chk("R12 functional enable", a_dout_en, 1);
    load_mode(2'b01);
    chk("R12 hold cleared a", {a_dout_en, a_dout}, 0);
    chk("R12 hold cleared b", {b_dout_en, b_dout}, 0);
    load_mode(2'b00);

    // R1 / R2 directed
    a_le = 1'b1; a_din = 9'h1A5; #1;
    chk("R1 transparent", a_dout, 9'h1A5);
    tick();
    a_le = 1'b0; a_din = 9'h05A; #1;
    chk("R2 hold after fall", a_dout, 9'h1A5);
    tick();
    chk("R2 still held", a_dout, 9'h1A5);

    // R3: loading while outputs are off
    a_oe_n = 1'b1; a_le = 1'b1; a_din = 9'h0F3; #1;
    chk("R3 outputs off", a_dout_en, 0);
    tick();
    a_le = 1'b0; a_din = 9'h000; tick();
    a_oe_n = 1'b0; #1;
    chk("R3 loaded while off", {a_dout_en, a_dout}, {1'b1, 9'h0F3});

    // R4: banks independent
    b_oe_n = 1'b0; b_le = 1'b1; b_din = 9'h133; tick();
    b_le = 1'b0; a_le = 1'b1; a_din = 9'h0CC; tick();
    a_le = 1'b0; b_din = 9'h1FF; #1;
    chk("R4 b unaffected by a load", b_dout, 9'h133);
    chk("R4 a loaded", a_dout, 9'h0CC);

    // R1 R2 R3 R4 random functional traffic
    for (int n = 0; n < 300; n++) begin
      a_din = W'($urandom); b_din = W'($urandom);
      a_le = 1'($urandom); b_le = 1'($urandom);
      a_oe_n = (($urandom % 4) == 0); b_oe_n = (($urandom % 4) == 0);
      #1;
      chk("R1/R2 random a", a_dout, a_exp());
      chk("R4 random b", b_dout, b_exp());
      chk("R3 random enables", {a_dout_en, b_dout_en}, {~a_oe_n, ~b_oe_n});
      tick();
    end

    // R6 capture with shift also high, then R5 shift-out
    for (int n = 0; n < 4; n++) begin
      a_din = W'($urandom); b_din = W'($urandom);
      a_le = 1'($urandom); b_le = 1'($urandom);
      a_oe_n = 1'($urandom); b_oe_n = 1'($urandom);
      #1;
      exp_img = cap_image(a_din, b_din, a_exp(), b_exp(), a_le, a_oe_n, b_le, b_oe_n);
      scan_capture = 1'b1; scan_shift = 1'b1;
      tick();
      scan_capture = 1'b0; scan_shift = 1'b0;
      p1 = {$urandom, $urandom};
      shift_in(p1, got);
      chk("R6 R5 captured image", got, exp_img);
      a_le = 1'b0;
    end

    // R7: update in functional mode leaves outputs on the core
    a_oe_n = 1'b0; b_oe_n = 1'b0; a_le = 1'b0; b_le = 1'b0;
    p1 = {$urandom, $urandom};
    shift_in(p1, got);
    do_update();
    chk("R7 functional ignores hold a", {a_dout_en, a_dout}, {1'b1, ma_q});
    chk("R7 functional ignores hold b", {b_dout_en, b_dout}, {1'b1, mb_q});

    // R8: external test drives from hold, core inputs have no effect
    load_mode(2'b01);
    check_from_image("R8 extest", p1);
    a_le = 1'b1; a_din = ~a_din; a_oe_n = 1'b1; b_oe_n = 1'b1; #1;
    check_from_image("R8 core ignored", p1);
    tick();
    a_le = 1'b0;
    for (int n = 0; n < 4; n++) begin
      p2 = {$urandom, $urandom};
      shift_in(p2, got);
      chk("R5 previous image shifted out", got, p1);
      do_update();
      check_from_image("R7 R8 random update", p2);
      p1 = p2;
    end

    // R9: clamp freezes the hold stages
    load_mode(2'b10);
    check_from_image("R9 clamp drives hold", p1);
    p2 = ~p1;
    shift_in(p2, got);
    do_update();
    check_from_image("R9 update ignored", p1);
    load_mode(2'b01);
    check_from_image("R9 hold unchanged after clamp", p1);
    do_update();
    check_from_image("R8 update after clamp", p2);

    // R10 / R11: high impedance and mode timing
    a_oe_n = 1'b0; b_oe_n = 1'b0;
    load_mode(2'b11);
    chk("R10 highz", {a_dout_en, b_dout_en}, 2'b00);
    mode_sel = 2'b00; ir_update = 1'b1; #1;
    chk("R11 mode not yet applied", {a_dout_en, b_dout_en}, 2'b00);
    tick();
    ir_update = 1'b0;
    chk("R11 functional after load", {a_dout_en, b_dout_en}, 2'b11);
    mode_sel = 2'b11; #1;
    chk("R11 select alone ignored", {a_dout_en, b_dout_en}, 2'b11);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule